// File: doc/BRIEF.md
# Circular Global Branch History Register

This block holds the global branch history of a branch predictor as a 256-bit buffer whose bits never move. A pointer marks the newest recorded outcome. Stepping from the pointer towards higher indices walks back through older outcomes, and the pointer wraps modulo the buffer length. Recording a branch means moving the pointer one place lower and writing the outcome at the new position. One update may record two branches.

Four sources can propose an update in the same cycle: the s1, s2 and s3 predictor stages and an external redirect. Each proposal carries a valid flag, a new pointer, a full-width write-data vector and a full-width write-enable mask. The pointer and the write data come from the highest-priority valid source. The redirect ranks highest, then s3, then s2, then s1. When no source is valid, the current state is held. The write-enable masks of all four sources are ORed together, whether or not the source is valid. A buffer bit changes only where the combined mask is set.

The block also presents the history rotated right by the pointer. Bit 0 of that view is the newest outcome and bit 255 is the oldest. The per-stage proposals are computed outside the block.

Top module: `ghr_ring_top`

## Requirements
- R1: While reset is asserted and after it is released, the pointer output reads 0 and the history view reads all zeros.
- R2: When the redirect source is valid, the next pointer equals the redirect pointer, whatever the stage sources present, and the enabled buffer bits take the redirect write data.
- R3: Without a valid redirect, the winning source is s3 over s2 over s1 for both the pointer and the write data.
- R4: When no source is valid, the pointer keeps its value and the buffer does not change, even if some write masks are set.
- R5: The effective write mask is the OR of all four masks. A bit that is enabled only by a non-winning source's mask takes the winning source's data bit.
- R6: A buffer bit whose combined mask bit is 0 keeps its value.
- R7: History view bit i equals buffer bit (pointer + i) mod 256. View bit 0 is the newest outcome.
- R8: Pointer values wrap modulo 256. From pointer 0, a not-taken then taken pair is recorded with pointer 254, a 0 written at index 255 and a 1 at index 254. The view then shows bit 0 = 1 and bit 1 = 0.
- R9: Pointer and history outputs are registered. An accepted proposal appears after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s1Valid | input | 1 | s1 proposal valid |
| s1Ptr | input | 8 | s1 proposed pointer |
| s1Wdata | input | 256 | s1 write data |
| s1Wmask | input | 256 | s1 write enables |
| s2Valid | input | 1 | s2 proposal valid |
| s2Ptr | input | 8 | s2 proposed pointer |
| s2Wdata | input | 256 | s2 write data |
| s2Wmask | input | 256 | s2 write enables |
| s3Valid | input | 1 | s3 proposal valid |
| s3Ptr | input | 8 | s3 proposed pointer |
| s3Wdata | input | 256 | s3 write data |
| s3Wmask | input | 256 | s3 write enables |
| redirValid | input | 1 | External redirect valid |
| redirPtr | input | 8 | Redirect pointer |
| redirWdata | input | 256 | Redirect write data |
| redirWmask | input | 256 | Redirect write enables |
| histPtr | output | 8 | Current newest-bit pointer |
| histView | output | 256 | History rotated so bit 0 is newest |

## Verification
A wrong pick in the priority select shows up one clock later as a wrong histPtr value. It also shifts every bit of histView at the same moment, so it cannot stay hidden. A corrupted buffer bit stays invisible only until the pointer places it inside the view, and the view always covers the whole buffer. Any stray or missing write is therefore visible on histView in the cycle after the faulty edge. A reference model is compared against both outputs on every cycle, so the first mismatch is reported within one clock of the fault.

// File: rtl/ghr_pkg.sv
package ghr_pkg;
  localparam int NUM_SRC = 4;  // index 0 = s1, 1 = s2, 2 = s3, 3 = redirect

  typedef struct packed {
    logic               anyValid;
    logic [NUM_SRC-1:0] pick;   // one-hot winner, highest index wins
  } ghrStrobe_t;
endpackage

// File: rtl/ghr_ctrl.sv
module ghr_ctrl
  import ghr_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcValid,
  output ghrStrobe_t         strobe
);
  logic [NUM_SRC-1:0] pick;

  // Later index overrides earlier: ascending priority order.
  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (srcValid[k]) begin
        pick    = '0;
        pick[k] = 1'b1;
      end
    end
  end

  assign strobe.pick     = pick;
  assign strobe.anyValid = |srcValid;
endmodule

// File: rtl/ghr_dp.sv
module ghr_dp
  import ghr_pkg::*;
#(
  parameter int HIST_LEN = 256,
  localparam int PTR_W   = $clog2(HIST_LEN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ghrStrobe_t                        strobe,
  input  logic [NUM_SRC-1:0][PTR_W-1:0]    srcPtr,
  input  logic [NUM_SRC-1:0][HIST_LEN-1:0] srcWdata,
  input  logic [NUM_SRC-1:0][HIST_LEN-1:0] srcWmask,
  output logic [PTR_W-1:0]                 ptrQ,
  output logic [HIST_LEN-1:0]              viewOut
);
  logic [HIST_LEN-1:0]   bufQ, bufNext, selData, maskOr;
  logic [PTR_W-1:0]      selPtr;
  logic [2*HIST_LEN-1:0] dbl, dblShift;

  always_comb begin
    selPtr  = ptrQ;
    selData = bufQ;
    maskOr  = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      maskOr = maskOr | srcWmask[k];
      if (strobe.pick[k]) begin
        selPtr  = srcPtr[k];
        selData = srcWdata[k];
      end
    end
    bufNext = (bufQ & ~maskOr) | (selData & maskOr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ <= '0;
      bufQ <= '0;
    end else begin
      ptrQ <= selPtr;
      bufQ <= bufNext;
    end
  end

  // Rotate right by the pointer: view[i] = buf[(ptr+i) mod HIST_LEN]
  assign dbl      = {bufQ, bufQ};
  assign dblShift = dbl >> ptrQ;
  assign viewOut  = dblShift[HIST_LEN-1:0];

  a_r3_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.pick));

  a_r2_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pick[NUM_SRC-1] |=> ptrQ == $past(srcPtr[NUM_SRC-1]));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.anyValid |=> $stable(ptrQ) && $stable(bufQ));

  a_r6_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bufQ ^ $past(bufQ)) & ~$past(maskOr)) == '0);

  a_r3_s3_over_stages: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pick[2] |=> ptrQ == $past(srcPtr[2]));
endmodule

// File: rtl/ghr_ring_top.sv
module ghr_ring_top
  import ghr_pkg::*;
#(
  parameter int HIST_LEN = 256,
  localparam int PTR_W   = $clog2(HIST_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1Valid,
  input  logic [PTR_W-1:0]    s1Ptr,
  input  logic [HIST_LEN-1:0] s1Wdata,
  input  logic [HIST_LEN-1:0] s1Wmask,
  input  logic                s2Valid,
  input  logic [PTR_W-1:0]    s2Ptr,
  input  logic [HIST_LEN-1:0] s2Wdata,
  input  logic [HIST_LEN-1:0] s2Wmask,
  input  logic                s3Valid,
  input  logic [PTR_W-1:0]    s3Ptr,
  input  logic [HIST_LEN-1:0] s3Wdata,
  input  logic [HIST_LEN-1:0] s3Wmask,
  input  logic                redirValid,
  input  logic [PTR_W-1:0]    redirPtr,
  input  logic [HIST_LEN-1:0] redirWdata,
  input  logic [HIST_LEN-1:0] redirWmask,
  output logic [PTR_W-1:0]    histPtr,
  output logic [HIST_LEN-1:0] histView
);
  ghrStrobe_t                        strobe;
  logic [NUM_SRC-1:0]                srcValid;
  logic [NUM_SRC-1:0][PTR_W-1:0]    srcPtr;
  logic [NUM_SRC-1:0][HIST_LEN-1:0] srcWdata, srcWmask;

  assign srcValid = {redirValid, s3Valid, s2Valid, s1Valid};
  assign srcPtr   = {redirPtr, s3Ptr, s2Ptr, s1Ptr};
  assign srcWdata = {redirWdata, s3Wdata, s2Wdata, s1Wdata};
  assign srcWmask = {redirWmask, s3Wmask, s2Wmask, s1Wmask};

  ghr_ctrl ctrl_i (
    .srcValid (srcValid),
    .strobe   (strobe)
  );

  ghr_dp #(.HIST_LEN(HIST_LEN)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .srcPtr   (srcPtr),
    .srcWdata (srcWdata),
    .srcWmask (srcWmask),
    .ptrQ     (histPtr),
    .viewOut  (histView)
  );
endmodule

// File: tb/ghr_ring_top_tb_top.sv
`timescale 1ns/1ps
module ghr_ring_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]   vld;
  logic [7:0]   ptrIn [4];
  logic [255:0] wdIn  [4];
  logic [255:0] mkIn  [4];
  logic [7:0]   histPtr;
  logic [255:0] histView;

  ghr_ring_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .s1Valid(vld[0]), .s1Ptr(ptrIn[0]), .s1Wdata(wdIn[0]), .s1Wmask(mkIn[0]),
    .s2Valid(vld[1]), .s2Ptr(ptrIn[1]), .s2Wdata(wdIn[1]), .s2Wmask(mkIn[1]),
    .s3Valid(vld[2]), .s3Ptr(ptrIn[2]), .s3Wdata(wdIn[2]), .s3Wmask(mkIn[2]),
    .redirValid(vld[3]), .redirPtr(ptrIn[3]), .redirWdata(wdIn[3]), .redirWmask(mkIn[3]),
    .histPtr(histPtr), .histView(histView)
  );

  int checks = 0;
  int fails  = 0;
  logic [255:0] mBuf;
  logic [7:0]   mPtr;

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic clearIn();
    vld = '0;
    for (int k = 0; k < 4; k++) begin
      ptrIn[k] = '0; wdIn[k] = '0; mkIn[k] = '0;
    end
  endtask

  task automatic chkBit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: bit actual %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [255:0] expView;
    for (int i = 0; i < 256; i++) expView[i] = mBuf[(int'(mPtr) + i) % 256];
    checks += 2;
    if (histPtr !== mPtr) begin
      fails++;
      $display("FAIL %s: histPtr actual %0d expected %0d", tag, histPtr, mPtr);
    end
    if (histView !== expView) begin
      fails++;
      $display("FAIL %s: histView actual %h expected %h", tag, histView, expView);
    end
  endtask

  // One clock: model consumes the inputs held across the rising edge.
  task automatic step(string tag);
    logic [255:0] orM, d;
    logic [7:0]   p;
    @(posedge clk);
    orM = '0; p = mPtr; d = mBuf;
    for (int k = 0; k < 4; k++) begin
      orM |= mkIn[k];
      if (vld[k]) begin p = ptrIn[k]; d = wdIn[k]; end
    end
    mBuf = (mBuf & ~orM) | (d & orM);
    mPtr = p;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clearIn();
    mBuf = '0; mPtr = '0;
    repeat (3) @(negedge clk);
    compare("R1");  // during reset
    rst_n = 1'b1;
    step("R1");

    // R2: redirect beats every stage
    for (int k = 0; k < 4; k++) begin
      vld[k] = 1'b1; ptrIn[k] = 8'(8'h10 * (k + 1)); wdIn[k] = rnd256(); mkIn[k] = rnd256();
    end
    step("R2");

    // R3: s3 > s2 > s1
    vld[3] = 1'b0; mkIn[3] = '0;
    step("R3");
    vld[2] = 1'b0;
    step("R3");
    vld[1] = 1'b0;
    step("R3");

    // R4: nothing valid, masks set
    clearIn();
    for (int k = 0; k < 4; k++) begin wdIn[k] = rnd256(); mkIn[k] = '1; ptrIn[k] = 8'hAA; end
    step("R4");

    // R5: mask only from invalid s1, s3 wins with data 1 at bit 10
    clearIn();
    vld[2] = 1'b1; ptrIn[2] = 8'd0; wdIn[2] = '1; mkIn[0][10] = 1'b1;
    step("R5");
    chkBit("R5", histView[10], 1'b1);

    // R6: only bit 5 enabled
    clearIn();
    vld[1] = 1'b1; ptrIn[1] = 8'd0; wdIn[1] = ~mBuf; mkIn[1][5] = 1'b1;
    step("R6");

    // R9: proposal not visible before the edge
    clearIn();
    vld[3] = 1'b1; ptrIn[3] = 8'd77;
    #1;
    checks++;
    if (histPtr !== mPtr) begin
      fails++;
      $display("FAIL R9: histPtr actual %0d expected %0d", histPtr, mPtr);
    end
    step("R9");

    // R8: wrap, not-taken then taken from pointer 0
    clearIn();
    vld[3] = 1'b1; ptrIn[3] = 8'd0;
    step("R8");
    clearIn();
    vld[1] = 1'b1; ptrIn[1] = 8'd254;
    mkIn[1][255] = 1'b1; wdIn[1][255] = 1'b0;
    mkIn[1][254] = 1'b1; wdIn[1][254] = 1'b1;
    step("R8");
    chkBit("R8", histView[0], 1'b1);
    chkBit("R8", histView[1], 1'b0);

    // R7: random traffic, full view compare each clock
    for (int n = 0; n < 3000; n++) begin
      clearIn();
      for (int k = 0; k < 4; k++) begin
        vld[k]   = ($urandom % 4) == 0;
        ptrIn[k] = 8'($urandom);
        wdIn[k]  = rnd256();
        if (($urandom % 3) == 0) mkIn[k] = rnd256() & rnd256();
        else begin
          mkIn[k][8'($urandom)] = 1'b1;
        end
      end
      step("R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule